// File: doc/BRIEF.md
# Five-Code Self-Starting Sequence Counter

A three-bit synchronous counter that steps through a fixed cycle of five codes that are not consecutive binary values. The state register drives the outputs directly, with no decoding after it. Each state bit is named: C is the most significant bit, then B, then A. Only an enabled clock advances the state. A synchronous reset returns the counter to the start of the cycle.

Three of the eight codes are not part of the cycle. The next-state logic sends each of them into the cycle in at most two enabled clocks, so a register that powers up holding one of these codes is still safe. For test, a preset input can place any code into the state register. This is the only way the bench can reach the unused codes.

Top module: `seq5_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` is 000 after that edge.
- R2: Reset has priority over both `load` and `en`: with `rst` high, `q` becomes 000 whatever those inputs are.
- R3: With `en` high and `rst` and `load` low, the state advances along the cycle 000 → 010 → 011 → 101 → 110 → 000, written as C B A.
- R4: With `en`, `rst` and `load` all low, `q` holds its value, and this includes the unused codes.
- R5: Unused code 001 moves to 110 on one enabled clock.
- R6: Unused code 100 moves to 010 on one enabled clock.
- R7: Unused code 111 moves to 100 on one enabled clock and then to 010, so it is in the cycle after two enabled clocks.
- R8: With `load` high and `rst` low, `q` takes the value of `load_code` on the next edge, whatever `en` is.
- R9: The outputs are the state bits themselves: `q[2]` is C, `q[1]` is B and `q[0]` is A. A loaded code appears on `q` bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to 000, highest priority |
| en | input | 1 | Count enable |
| load | input | 1 | Test-only preset strobe |
| load_code | input | 3 | Code written by the preset, as C B A |
| q | output | 3 | Present state, as C B A |

## Verification
The assertions assume that `rst`, `en`, `load` and `load_code` hold known 0/1 values at every rising edge, and that `rst` is high at the first edge. The bench meets this by driving every input only on the falling edge, starting with reset high. The transition checks for the cycle and for recovery only apply when neither reset nor preset is active. The bench therefore gives each unused code a cycle of its own: it places the code with the preset, then clocks it with the enable and the preset low.

// File: rtl/seq5_counter.sv
module seq5_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic [2:0] load_code,
  output logic [2:0] q
);
  logic [2:0] st;
  logic [2:0] nxt;

  // resolved don't-cares: 001->110, 100->010, 111->100
  assign nxt[2] = st[0];
  assign nxt[1] = ~st[1] | (~st[0] & ~st[2]);
  assign nxt[0] = st[1] & ~st[2];

  always_ff @(posedge clk) begin
    if (rst)       st <= 3'b000;
    else if (load) st <= load_code;
    else if (en)   st <= nxt;
  end

  assign q = st;

  p_reset_r1: assert property (@(posedge clk) rst |=> q == 3'b000);

  p_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q == 3'b101) |=> q == 3'b110);

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q == 3'b110) |=> q == 3'b000);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(q));

  p_recover_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q == 3'b001) |=> q == 3'b110);

  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q == 3'b100) |=> q == 3'b010);

  p_recover_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !load && q == 3'b111) |=> q == 3'b100);

  p_preset_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(load_code));
endmodule

// File: tb/sim_seq5_counter.sv
`timescale 1ns/1ps
module sim_seq5_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [2:0] load_code = 3'b000;
  logic [2:0] q;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq5_counter u0 (.clk(clk), .rst(rst), .en(en), .load(load), .load_code(load_code), .q(q));

  // {req[3:0], rst, en, load, code[2:0], expected q[2:0]}
  localparam int NV = 21;
  localparam logic [12:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b010}, // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b011}, // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b101}, // R3
    {4'd4, 1'b0, 1'b0, 1'b0, 3'b000, 3'b101}, // R4
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b110}, // R3
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b000}, // R3 wrap
    {4'd9, 1'b0, 1'b0, 1'b1, 3'b001, 3'b001}, // R9 / R8
    {4'd4, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001}, // R4 unused held
    {4'd5, 1'b0, 1'b1, 1'b0, 3'b000, 3'b110}, // R5
    {4'd8, 1'b0, 1'b1, 1'b1, 3'b100, 3'b100}, // R8 preset beats enable
    {4'd6, 1'b0, 1'b1, 1'b0, 3'b000, 3'b010}, // R6
    {4'd8, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111}, // R8
    {4'd4, 1'b0, 1'b0, 1'b0, 3'b000, 3'b111}, // R4 unused held
    {4'd7, 1'b0, 1'b1, 1'b0, 3'b000, 3'b100}, // R7 first step
    {4'd7, 1'b0, 1'b1, 1'b0, 3'b000, 3'b010}, // R7 second step
    {4'd2, 1'b1, 1'b1, 1'b1, 3'b101, 3'b000}, // R2
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b010}, // R3
    {4'd9, 1'b0, 1'b0, 1'b1, 3'b011, 3'b011}, // R9
    {4'd3, 1'b0, 1'b1, 1'b0, 3'b000, 3'b101}, // R3
    {4'd2, 1'b1, 1'b0, 1'b1, 3'b111, 3'b000}, // R2
    {4'd1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b000}  // R1
  };

  task automatic check(input logic [2:0] exp, input string req);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s: q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic l, input logic [2:0] c);
    rst = r; en = e; load = l; load_code = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit in_cycle(input logic [2:0] v);
    return v == 3'b000 || v == 3'b010 || v == 3'b011 || v == 3'b101 || v == 3'b110;
  endfunction

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, 3'b000);
    check(3'b000, "R1 reset state");
    step(1'b0, 1'b0, 1'b0, 3'b000);
    check(3'b000, "R4 idle after reset");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:3]);
      checks++;
      if (q !== VEC[i][2:0]) begin
        failures++;
        $display("FAIL R%0d vector %0d: q=%b expected=%b", VEC[i][12:9], i, q, VEC[i][2:0]);
      end
    end
    step(1'b0, 1'b0, 1'b0, 3'b000);

    // R7 / R5 / R6: every unused code is in the cycle within two enabled clocks
    for (int k = 0; k < 3; k++) begin
      logic [2:0] code;
      code = (k == 0) ? 3'b001 : (k == 1) ? 3'b100 : 3'b111;
      step(1'b0, 1'b0, 1'b1, code);
      check(code, "R8 preset unused code");
      step(1'b0, 1'b1, 1'b0, 3'b000);
      step(1'b0, 1'b1, 1'b0, 3'b000);
      checks++;
      if (!in_cycle(q)) begin
        failures++;
        $display("FAIL R7 recovery from %b: q=%b expected a cycle code", code, q);
      end
    end

    // R2: reset during counting with enable high
    step(1'b0, 1'b1, 1'b0, 3'b000);
    step(1'b1, 1'b1, 1'b0, 3'b000);
    check(3'b000, "R2 reset over enable");
    step(1'b0, 1'b1, 1'b0, 3'b000);
    check(3'b010, "R3 first step after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule